// File: doc/BRIEF.md
# Speculative Lock Elision Controller

This block sits between a core's load/store issue path and the memory side. When the core issues a store that takes a lock and an external confidence predictor says the lock can be skipped, the block does not perform that store. It runs the critical section speculatively instead. Stores made inside the section are kept in a small internal buffer. Loads are served from that buffer where they can be, and are otherwise sent to memory, with the cache line they touched recorded. Coherence traffic from other agents is compared against the set of lines read and the set of lines written during the section.

The section ends when the core writes the lock word back to the value it held before the acquire. That release store is also suppressed, and the buffered stores are drained to memory one per cycle. On a coherence conflict, a capacity overflow, an uncached access or a malformed release, the block does the following:
- discards the buffer;
- pulses a recover output so the core can restart;
- performs the lock acquire for real.

After such a failure it does not speculate again until the core's own release of that lock has gone to memory.

Top module: `sle_top`

## Requirements
- R1: After reset, `core_ready` is 1 and `spec_active`, `mem_vld`, `recover`, `sec_commit` and `sec_abort` are 0. `abort_count` is 0.
- R2: Request kinds are encoded as 0 = load, 1 = store, 2 = uncached load and 3 = uncached store. Outside a section, with no elision, every request appears on the memory port one cycle after it is accepted. `mem_we` equals bit 0 of the kind, and the address and data are unchanged.
- R3: A store (kind 1) accepted while idle, with `core_pred_elide` high, starts a section. `spec_active` is 1 in the following cycle and no memory transaction is issued for that store. The store's address, its data and `core_lock_prev` are saved.
- R4: While a section runs, no store reaches memory. A store to a word address that is already buffered replaces that entry's data in place.
- R5: While a section runs, a load of the lock address returns the saved pre-acquire value on `ld_fwd_data`, and a load of a buffered word returns its latest data. Both appear with `ld_fwd_vld` one cycle later and nothing on memory. Any other load goes to memory as a read, and its line enters the read set.
- R6: A store to the lock address whose data equals the saved pre-acquire value ends the section and is not performed. With k buffered entries, the entries are written to memory in the order they were first allocated, one per cycle, in cycles 1 to k after the release. `sec_commit` pulses in cycle k+1.
- R7: Lines are 64 bytes, and the snoop port carries a line address. The read set holds the lock line plus each line loaded from memory during the section. A snooped write to any line in the read set aborts the section. A snooped read of a line that is only read does not abort it.
- R8: A snooped read or write to any line holding a buffered store aborts the section.
- R9: On an abort, all buffered stores are discarded and `recover` pulses in the cycle after the trigger. In the cycle after that, memory receives a store of the acquire data to the lock address, `sec_abort` pulses and `abort_count` increases by 1, saturating at its maximum.
- R10: Each of the following aborts the section: a store to a new word when 8 entries are buffered, a load of a new line when the read set holds 8 lines, any uncached request, and a store to the lock address with a value other than the saved one.
- R11: After an abort, stores with `core_pred_elide` high pass to memory without starting a section. This lasts until a store to the lock address has gone to memory.
- R12: `sec_commit` and `sec_abort` never pulse in the same cycle. `abort_count` changes only together with `sec_abort`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| core_req_vld | input | 1 | Core request valid, taken when `core_ready` is 1 |
| core_req_kind | input | 2 | 0 load, 1 store, 2 uncached load, 3 uncached store |
| core_req_addr | input | ADDR_W | Byte address of the request |
| core_req_data | input | DATA_W | Store data |
| core_pred_elide | input | 1 | Predictor says this store is an elidable lock acquire |
| core_lock_prev | input | DATA_W | Value the lock word held before the acquire |
| core_ready | output | 1 | Block accepts a request this cycle |
| ld_fwd_vld | output | 1 | Load answered from speculative state |
| ld_fwd_data | output | DATA_W | Forwarded load data |
| snp_vld | input | 1 | Snoop from another agent valid |
| snp_we | input | 1 | Snoop is a write (1) or a read (0) |
| snp_line | input | ADDR_W-6 | Snooped line address (byte address divided by 64) |
| mem_vld | output | 1 | Memory transaction valid |
| mem_we | output | 1 | Memory transaction is a write |
| mem_addr | output | ADDR_W | Memory address |
| mem_wdata | output | DATA_W | Memory write data |
| spec_active | output | 1 | A critical section is running speculatively |
| recover | output | 1 | One-cycle restart request to the core |
| sec_commit | output | 1 | One-cycle pulse: section committed |
| sec_abort | output | 1 | One-cycle pulse: section aborted |
| abort_count | output | ABORT_CNT_W | Saturating count of aborted sections |

## Verification
Each request or snoop is driven in the cycle before a rising edge, and everything it causes is registered. The bench therefore reads pass-through memory transactions, forwarded loads, `spec_active` and `recover` one cycle after the request is taken. The real lock store and `sec_abort` come one cycle later again. A commit is counted from the release: k drain writes in cycles 1 to k, then `sec_commit` in cycle k+1. Every memory transaction is compared in order against a queue of expected items, and an unexpected transaction counts as a failure. All sampling happens on the falling edge, so each value is read in the exact cycle it is due.

// File: rtl/sle_pkg.sv
package sle_pkg;
  typedef enum logic [1:0] {
    K_LOAD     = 2'd0,
    K_STORE    = 2'd1,
    K_UC_LOAD  = 2'd2,
    K_UC_STORE = 2'd3
  } req_kind_e;

  typedef enum logic [1:0] {
    S_IDLE   = 2'd0,
    S_SPEC   = 2'd1,
    S_COMMIT = 2'd2,
    S_ABORT  = 2'd3
  } sle_state_e;
endpackage

// File: rtl/sle_store_buf.sv
// Speculative store buffer: word-exact lookup for overwrite and forwarding,
// line-granular lookup for snoop conflicts, in-order read port for draining.
module sle_store_buf #(
  parameter int DEPTH    = 8,
  parameter int ADDR_W   = 32,
  parameter int DATA_W   = 32,
  parameter int LINE_OFF = 6
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         clr,
  input  logic                         wr_en,
  input  logic [ADDR_W-1:0]            addr,
  input  logic [DATA_W-1:0]            wr_data,
  output logic                         lk_hit,
  output logic [DATA_W-1:0]            lk_data,
  input  logic [ADDR_W-LINE_OFF-1:0]   snp_tag,
  output logic                         snp_hit,
  output logic                         full,
  output logic [$clog2(DEPTH+1)-1:0]   count,
  input  logic [$clog2(DEPTH)-1:0]     rd_idx,
  output logic [ADDR_W-1:0]            rd_addr,
  output logic [DATA_W-1:0]            rd_data
);
  localparam int CNT_W = $clog2(DEPTH+1);

  logic [CNT_W-1:0]  cnt_q;
  logic [ADDR_W-1:0] ent_addr [DEPTH];
  logic [DATA_W-1:0] ent_data [DEPTH];
  logic [DEPTH-1:0]  match_w;
  logic [DEPTH-1:0]  match_l;
  logic              alloc;

  assign full  = (cnt_q == CNT_W'(DEPTH));
  assign count = cnt_q;
  assign alloc = wr_en && !lk_hit && !full;

  for (genvar i = 0; i < DEPTH; i++) begin : g_ent
    logic [ADDR_W-1:0] a_q;
    logic [DATA_W-1:0] d_q;
    logic              live;
    logic              take_addr;
    logic              take_data;

    assign live      = (CNT_W'(i) < cnt_q);
    assign match_w[i] = live && (a_q == addr);
    assign match_l[i] = live && (a_q[ADDR_W-1:LINE_OFF] == snp_tag);
    assign take_addr = alloc && (cnt_q == CNT_W'(i));
    assign take_data = take_addr || (wr_en && match_w[i]);

    always_ff @(posedge clk) begin
      if (take_addr) a_q <= addr;
    end

    always_ff @(posedge clk) begin
      if (take_data) d_q <= wr_data;
    end

    assign ent_addr[i] = a_q;
    assign ent_data[i] = d_q;
  end

  assign lk_hit  = |match_w;
  assign snp_hit = |match_l;

  always_comb begin
    lk_data = '0;
    for (int i = 0; i < DEPTH; i++) begin
      if (match_w[i]) lk_data = ent_data[i];
    end
  end

  assign rd_addr = ent_addr[rd_idx];
  assign rd_data = ent_data[rd_idx];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     cnt_q <= '0;
    else if (clr)   cnt_q <= '0;
    else if (alloc) cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/sle_line_set.sv
// Set of cache-line tags read during a section; deduplicating insert, snoop probe.
module sle_line_set #(
  parameter int DEPTH = 8,
  parameter int TAG_W = 26
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             ins_en,
  input  logic [TAG_W-1:0] ins_tag,
  output logic             ins_hit,
  input  logic [TAG_W-1:0] snp_tag,
  output logic             snp_hit,
  output logic             full
);
  localparam int CNT_W = $clog2(DEPTH+1);

  logic [CNT_W-1:0] cnt_q;
  logic [DEPTH-1:0] hit_i;
  logic [DEPTH-1:0] hit_s;
  logic             add;

  assign full = (cnt_q == CNT_W'(DEPTH));
  assign add  = ins_en && !ins_hit && !full;

  for (genvar i = 0; i < DEPTH; i++) begin : g_tag
    logic [TAG_W-1:0] t_q;
    logic             live;
    assign live     = (CNT_W'(i) < cnt_q);
    assign hit_i[i] = live && (t_q == ins_tag);
    assign hit_s[i] = live && (t_q == snp_tag);

    always_ff @(posedge clk) begin
      if (add && (cnt_q == CNT_W'(i))) t_q <= ins_tag;
    end
  end

  assign ins_hit = |hit_i;
  assign snp_hit = |hit_s;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   cnt_q <= '0;
    else if (clr) cnt_q <= '0;
    else if (add) cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/sle_top.sv
module sle_top #(
  parameter int ADDR_W      = 32,
  parameter int DATA_W      = 32,
  parameter int WB_DEPTH    = 8,
  parameter int RS_DEPTH    = 8,
  parameter int LINE_BYTES  = 64,
  parameter int ABORT_CNT_W = 16
) (
  input  logic                                    clk,
  input  logic                                    rst_n,
  input  logic                                    core_req_vld,
  input  logic [1:0]                              core_req_kind,
  input  logic [ADDR_W-1:0]                       core_req_addr,
  input  logic [DATA_W-1:0]                       core_req_data,
  input  logic                                    core_pred_elide,
  input  logic [DATA_W-1:0]                       core_lock_prev,
  output logic                                    core_ready,
  output logic                                    ld_fwd_vld,
  output logic [DATA_W-1:0]                       ld_fwd_data,
  input  logic                                    snp_vld,
  input  logic                                    snp_we,
  input  logic [ADDR_W-$clog2(LINE_BYTES)-1:0]    snp_line,
  output logic                                    mem_vld,
  output logic                                    mem_we,
  output logic [ADDR_W-1:0]                       mem_addr,
  output logic [DATA_W-1:0]                       mem_wdata,
  output logic                                    spec_active,
  output logic                                    recover,
  output logic                                    sec_commit,
  output logic                                    sec_abort,
  output logic [ABORT_CNT_W-1:0]                  abort_count
);
  import sle_pkg::*;

  localparam int LINE_OFF = $clog2(LINE_BYTES);
  localparam int TAG_W    = ADDR_W - LINE_OFF;
  localparam int WB_IDX_W = $clog2(WB_DEPTH);
  localparam int WB_CNT_W = $clog2(WB_DEPTH+1);

  sle_state_e state_q, state_d;
  logic [ADDR_W-1:0]      lock_addr_q, lock_addr_d;
  logic [DATA_W-1:0]      lock_prev_q, lock_prev_d;
  logic [DATA_W-1:0]      acq_data_q, acq_data_d;
  logic                   hold_q, hold_d;
  logic [WB_CNT_W-1:0]    drain_q, drain_d;
  logic                   mem_vld_d, mem_we_d;
  logic [ADDR_W-1:0]      mem_addr_d;
  logic [DATA_W-1:0]      mem_wdata_d;
  logic                   fwd_vld_d;
  logic [DATA_W-1:0]      fwd_data_d;
  logic                   recover_d, commit_d, abort_d;
  logic [ABORT_CNT_W-1:0] abort_cnt_d;

  logic                   wb_wr, wb_clr, wb_hit, wb_full, wb_snp_hit;
  logic [DATA_W-1:0]      wb_lk_data;
  logic [WB_CNT_W-1:0]    wb_count;
  logic [ADDR_W-1:0]      wb_rd_addr;
  logic [DATA_W-1:0]      wb_rd_data;
  logic                   rs_ins, rs_clr, rs_hit, rs_full, rs_snp_hit;

  logic                   snp_conflict, is_lock, abort_go;

  sle_store_buf #(
    .DEPTH(WB_DEPTH), .ADDR_W(ADDR_W), .DATA_W(DATA_W), .LINE_OFF(LINE_OFF)
  ) u_wbuf (
    .clk(clk), .rst_n(rst_n), .clr(wb_clr), .wr_en(wb_wr),
    .addr(core_req_addr), .wr_data(core_req_data),
    .lk_hit(wb_hit), .lk_data(wb_lk_data),
    .snp_tag(snp_line), .snp_hit(wb_snp_hit),
    .full(wb_full), .count(wb_count),
    .rd_idx(drain_q[WB_IDX_W-1:0]), .rd_addr(wb_rd_addr), .rd_data(wb_rd_data)
  );

  sle_line_set #(
    .DEPTH(RS_DEPTH), .TAG_W(TAG_W)
  ) u_rset (
    .clk(clk), .rst_n(rst_n), .clr(rs_clr), .ins_en(rs_ins),
    .ins_tag(core_req_addr[ADDR_W-1:LINE_OFF]), .ins_hit(rs_hit),
    .snp_tag(snp_line), .snp_hit(rs_snp_hit), .full(rs_full)
  );

  assign snp_conflict = snp_vld && ((snp_we && rs_snp_hit) || wb_snp_hit);
  assign is_lock      = (core_req_addr == lock_addr_q);
  assign core_ready   = (state_q == S_IDLE) || (state_q == S_SPEC);
  assign spec_active  = (state_q == S_SPEC);

  // next-state and output decode
  always_comb begin
    state_d     = state_q;
    lock_addr_d = lock_addr_q;
    lock_prev_d = lock_prev_q;
    acq_data_d  = acq_data_q;
    hold_d      = hold_q;
    drain_d     = drain_q;
    mem_vld_d   = 1'b0;
    mem_we_d    = 1'b0;
    mem_addr_d  = mem_addr;
    mem_wdata_d = mem_wdata;
    fwd_vld_d   = 1'b0;
    fwd_data_d  = ld_fwd_data;
    recover_d   = 1'b0;
    commit_d    = 1'b0;
    abort_d     = 1'b0;
    abort_cnt_d = abort_count;
    wb_wr       = 1'b0;
    wb_clr      = 1'b0;
    rs_ins      = 1'b0;
    rs_clr      = 1'b0;
    abort_go    = 1'b0;

    unique case (state_q)
      S_IDLE: begin
        if (core_req_vld) begin
          if (core_req_kind == K_STORE && core_pred_elide && !hold_q) begin
            state_d     = S_SPEC;
            lock_addr_d = core_req_addr;
            lock_prev_d = core_lock_prev;
            acq_data_d  = core_req_data;
            rs_ins      = 1'b1;
          end else begin
            mem_vld_d   = 1'b1;
            mem_we_d    = core_req_kind[0];
            mem_addr_d  = core_req_addr;
            mem_wdata_d = core_req_data;
            if (core_req_kind[0] && is_lock) hold_d = 1'b0;
          end
        end
      end
      S_SPEC: begin
        if (snp_conflict) begin
          abort_go = 1'b1;
        end else if (core_req_vld) begin
          unique case (core_req_kind)
            K_STORE: begin
              if (is_lock) begin
                if (core_req_data == lock_prev_q) begin
                  state_d = S_COMMIT;
                  drain_d = '0;
                  rs_clr  = 1'b1;
                end else begin
                  abort_go = 1'b1;
                end
              end else if (!wb_hit && wb_full) begin
                abort_go = 1'b1;
              end else begin
                wb_wr = 1'b1;
              end
            end
            K_LOAD: begin
              if (is_lock) begin
                fwd_vld_d  = 1'b1;
                fwd_data_d = lock_prev_q;
              end else if (wb_hit) begin
                fwd_vld_d  = 1'b1;
                fwd_data_d = wb_lk_data;
              end else if (!rs_hit && rs_full) begin
                abort_go = 1'b1;
              end else begin
                rs_ins      = 1'b1;
                mem_vld_d   = 1'b1;
                mem_addr_d  = core_req_addr;
                mem_wdata_d = core_req_data;
              end
            end
            default: abort_go = 1'b1;
          endcase
        end
        if (abort_go) begin
          state_d   = S_ABORT;
          recover_d = 1'b1;
          rs_clr    = 1'b1;
          wb_clr    = 1'b1;
          hold_d    = 1'b1;
        end
      end
      S_COMMIT: begin
        if (drain_q < wb_count) begin
          mem_vld_d   = 1'b1;
          mem_we_d    = 1'b1;
          mem_addr_d  = wb_rd_addr;
          mem_wdata_d = wb_rd_data;
          drain_d     = drain_q + 1'b1;
        end else begin
          state_d  = S_IDLE;
          commit_d = 1'b1;
          wb_clr   = 1'b1;
        end
      end
      S_ABORT: begin
        mem_vld_d   = 1'b1;
        mem_we_d    = 1'b1;
        mem_addr_d  = lock_addr_q;
        mem_wdata_d = acq_data_q;
        abort_d     = 1'b1;
        if (abort_count != '1) abort_cnt_d = abort_count + 1'b1;
        state_d     = S_IDLE;
      end
      default: state_d = S_IDLE;
    endcase
  end

  // state and output registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q     <= S_IDLE;
      lock_addr_q <= '0;
      lock_prev_q <= '0;
      acq_data_q  <= '0;
      hold_q      <= 1'b0;
      drain_q     <= '0;
      mem_vld     <= 1'b0;
      mem_we      <= 1'b0;
      mem_addr    <= '0;
      mem_wdata   <= '0;
      ld_fwd_vld  <= 1'b0;
      ld_fwd_data <= '0;
      recover     <= 1'b0;
      sec_commit  <= 1'b0;
      sec_abort   <= 1'b0;
      abort_count <= '0;
    end else begin
      state_q     <= state_d;
      lock_addr_q <= lock_addr_d;
      lock_prev_q <= lock_prev_d;
      acq_data_q  <= acq_data_d;
      hold_q      <= hold_d;
      drain_q     <= drain_d;
      mem_vld     <= mem_vld_d;
      mem_we      <= mem_we_d;
      mem_addr    <= mem_addr_d;
      mem_wdata   <= mem_wdata_d;
      ld_fwd_vld  <= fwd_vld_d;
      ld_fwd_data <= fwd_data_d;
      recover     <= recover_d;
      sec_commit  <= commit_d;
      sec_abort   <= abort_d;
      abort_count <= abort_cnt_d;
    end
  end
endmodule

// File: rtl/sle_chk.sv
module sle_chk #(
  parameter int ADDR_W   = 32,
  parameter int DATA_W   = 32,
  parameter int WB_DEPTH = 8,
  parameter int CNT_W    = 16
) (
  input logic                         clk,
  input logic                         rst_n,
  input logic                         spec_active,
  input logic                         recover,
  input logic                         sec_commit,
  input logic                         sec_abort,
  input logic                         mem_vld,
  input logic                         mem_we,
  input logic [ADDR_W-1:0]            mem_addr,
  input logic [DATA_W-1:0]            mem_wdata,
  input logic                         ld_fwd_vld,
  input logic [CNT_W-1:0]             abort_count,
  input logic [ADDR_W-1:0]            lock_addr,
  input logic [DATA_W-1:0]            acq_data,
  input logic [$clog2(WB_DEPTH+1)-1:0] wb_count
);
  // R4: nothing speculative is written to memory while a section runs
  p_spec_no_write_r4: assert property (@(posedge clk) disable iff (!rst_n)
    spec_active |=> !(mem_vld && mem_we));

  // R5: a load is either forwarded or sent to memory, never both
  p_fwd_or_mem_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ld_fwd_vld |-> !mem_vld);

  // R9: recover only follows a running section
  p_recover_src_r9: assert property (@(posedge clk) disable iff (!rst_n)
    recover |-> $past(spec_active));

  // R9: recover is followed by the real lock store and the abort pulse
  p_real_acquire_r9: assert property (@(posedge clk) disable iff (!rst_n)
    recover |=> (mem_vld && mem_we && mem_addr == lock_addr &&
                 mem_wdata == acq_data && sec_abort));

  // R9: abort count steps by one on each abort below saturation
  p_cnt_step_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (sec_abort && $past(abort_count) != '1) |-> abort_count == $past(abort_count) + 1'b1);

  // R10: the store buffer never holds more than its depth
  p_no_overflow_r10: assert property (@(posedge clk) disable iff (!rst_n)
    wb_count <= ($clog2(WB_DEPTH+1))'(WB_DEPTH));

  // R12: a section has exactly one outcome
  p_one_outcome_r12: assert property (@(posedge clk) disable iff (!rst_n)
    !(sec_commit && sec_abort));

  // R12: abort count moves only with an abort
  p_cnt_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
    !sec_abort |-> abort_count == $past(abort_count));
endmodule

bind sle_top sle_chk #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .WB_DEPTH(WB_DEPTH), .CNT_W(ABORT_CNT_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .spec_active(spec_active), .recover(recover),
  .sec_commit(sec_commit), .sec_abort(sec_abort), .mem_vld(mem_vld),
  .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
  .ld_fwd_vld(ld_fwd_vld), .abort_count(abort_count),
  .lock_addr(lock_addr_q), .acq_data(acq_data_q), .wb_count(wb_count)
);

// File: tb/sim_sle_top.sv
module sim_sle_top;
  localparam logic [1:0] LD = 2'd0, ST = 2'd1, UCL = 2'd2;
  localparam logic [31:0] LK = 32'h0000_0100;

  logic        clk, rst_n;
  logic        core_req_vld, core_pred_elide;
  logic [1:0]  core_req_kind;
  logic [31:0] core_req_addr, core_req_data, core_lock_prev;
  logic        core_ready, ld_fwd_vld;
  logic [31:0] ld_fwd_data;
  logic        snp_vld, snp_we;
  logic [25:0] snp_line;
  logic        mem_vld, mem_we;
  logic [31:0] mem_addr, mem_wdata;
  logic        spec_active, recover, sec_commit, sec_abort;
  logic [15:0] abort_count;

  sle_top u0 (.*);

  initial clk = 1'b0;
  always #4 clk = ~clk;

  int n_run = 0, n_fail = 0;

  typedef struct {
    logic        we;
    logic [31:0] addr;
    logic [31:0] data;
    string       tag;
  } mtx_t;
  mtx_t exp_q[$];

  task automatic chk(bit ok, string tag, logic [63:0] act, logic [63:0] exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic expect_mem(logic we, logic [31:0] a, logic [31:0] d, string tag);
    mtx_t e;
    e.we = we; e.addr = a; e.data = d; e.tag = tag;
    exp_q.push_back(e);
  endtask

  // monitor: every memory transaction must match the next expected item
  always @(negedge clk) begin : mon
    mtx_t e;
    if (rst_n && mem_vld) begin
      if (exp_q.size() == 0) begin
        chk(1'b0, "R4 unexpected memory transaction", {mem_we, mem_addr}, 0);
      end else begin
        e = exp_q.pop_front();
        chk(mem_we == e.we && mem_addr == e.addr && mem_wdata == e.data,
            e.tag, {mem_we, mem_addr, mem_wdata}, {e.we, e.addr, e.data});
      end
    end
  end

  task automatic drive(logic [1:0] k, logic [31:0] a, logic [31:0] d,
                       logic pred, logic [31:0] prev);
    while (!core_ready) @(negedge clk);
    core_req_vld = 1'b1; core_req_kind = k; core_req_addr = a;
    core_req_data = d; core_pred_elide = pred; core_lock_prev = prev;
    @(negedge clk);
    core_req_vld = 1'b0; core_pred_elide = 1'b0;
  endtask

  task automatic snoop(logic we, logic [31:0] byte_addr);
    snp_vld = 1'b1; snp_we = we; snp_line = byte_addr[31:6];
    @(negedge clk);
    snp_vld = 1'b0;
  endtask

  task automatic acquire();
    drive(ST, LK, 32'h1, 1'b1, 32'h0);
  endtask

  task automatic release_real();
    expect_mem(1'b1, LK, 32'h0, "R11 real release");
    drive(ST, LK, 32'h0, 1'b0, 32'h0);
  endtask

  // lock store at the next cycle is checked by the monitor
  task automatic check_abort(string tag, int exp_cnt);
    chk(recover == 1'b1, tag, recover, 1);
    @(negedge clk);
    chk(sec_abort == 1'b1 && abort_count == 16'(exp_cnt), tag, abort_count, exp_cnt);
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    n_run++; n_fail++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin : main
    int n;
    rst_n = 1'b0; core_req_vld = 1'b0; core_req_kind = LD; core_req_addr = '0;
    core_req_data = '0; core_pred_elide = 1'b0; core_lock_prev = '0;
    snp_vld = 1'b0; snp_we = 1'b0; snp_line = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    chk(core_ready == 1'b1, "R1 core_ready", core_ready, 1);
    chk(!mem_vld && !spec_active, "R1 idle outputs", {mem_vld, spec_active}, 0);
    chk(!recover && !sec_commit && !sec_abort, "R1 pulses", {recover, sec_commit, sec_abort}, 0);
    chk(abort_count == 0, "R1 abort_count", abort_count, 0);

    // R2 pass-through
    expect_mem(1'b1, 32'h40, 32'hAA, "R2 store pass");
    drive(ST, 32'h40, 32'hAA, 1'b0, 0);
    expect_mem(1'b0, 32'h44, 32'h0, "R2 load pass");
    drive(LD, 32'h44, 32'h0, 1'b0, 0);
    expect_mem(1'b1, 32'h48, 32'h5, "R2 uncached store pass");
    drive(2'd3, 32'h48, 32'h5, 1'b0, 0);
    chk(spec_active == 1'b0, "R2 no section", spec_active, 0);

    // R3..R6 committed section
    acquire();
    chk(spec_active == 1'b1, "R3 section starts", spec_active, 1);
    drive(ST, 32'h1000, 32'd11, 1'b0, 0);
    drive(ST, 32'h2000, 32'd22, 1'b0, 0);
    drive(ST, 32'h1000, 32'd33, 1'b0, 0);
    chk(mem_vld == 1'b0, "R4 store held", mem_vld, 0);
    drive(LD, 32'h1000, 32'h0, 1'b0, 0);
    chk(ld_fwd_vld && ld_fwd_data == 32'd33, "R4 R5 overwrite forwarded", ld_fwd_data, 33);
    drive(LD, LK, 32'h0, 1'b0, 0);
    chk(ld_fwd_vld && ld_fwd_data == 32'h0, "R5 lock appears free", ld_fwd_data, 0);
    expect_mem(1'b0, 32'h3000, 32'h0, "R5 miss load to memory");
    drive(LD, 32'h3000, 32'h0, 1'b0, 0);
    chk(ld_fwd_vld == 1'b0, "R5 miss not forwarded", ld_fwd_vld, 0);
    snoop(1'b0, 32'h3004);
    chk(spec_active == 1'b1 && !recover, "R7 read of read line harmless", spec_active, 1);
    expect_mem(1'b1, 32'h1000, 32'd33, "R6 drain first");
    expect_mem(1'b1, 32'h2000, 32'd22, "R6 drain second");
    drive(ST, LK, 32'h0, 1'b0, 0);
    n = 0;
    while (!(sec_commit || sec_abort) && n < 50) begin @(negedge clk); n++; end
    chk(sec_commit && !sec_abort, "R6 R12 commit pulse", {sec_commit, sec_abort}, 2'b10);
    chk(n == 3, "R6 commit timing", n, 3);
    chk(exp_q.size() == 0, "R6 drain complete", exp_q.size(), 0);

    // R8 R9 snoop read of written line
    acquire();
    drive(ST, 32'h1000, 32'd7, 1'b0, 0);
    expect_mem(1'b1, LK, 32'h1, "R9 real acquire");
    snoop(1'b0, 32'h1004);
    check_abort("R8 R9 abort on written line", 1);

    // R11 no speculation until the release goes out
    expect_mem(1'b1, 32'h500, 32'h9, "R11 pass while held");
    drive(ST, 32'h500, 32'h9, 1'b1, 0);
    chk(spec_active == 1'b0, "R11 no section while held", spec_active, 0);
    expect_mem(1'b1, LK, 32'h0, "R11 release passes");
    drive(ST, LK, 32'h0, 1'b1, 0);
    chk(spec_active == 1'b0, "R11 release not elided", spec_active, 0);
    acquire();
    chk(spec_active == 1'b1, "R11 speculation resumes", spec_active, 1);
    expect_mem(1'b0, 32'h1000, 32'h0, "R9 discarded store not forwarded");
    drive(LD, 32'h1000, 32'h0, 1'b0, 0);
    chk(ld_fwd_vld == 1'b0, "R9 buffer discarded", ld_fwd_vld, 0);

    // R7 snoop write to lock line
    expect_mem(1'b1, LK, 32'h1, "R9 real acquire");
    snoop(1'b1, LK + 32'h8);
    check_abort("R7 write to read line", 2);
    release_real();

    // R10 store buffer capacity
    acquire();
    for (int i = 0; i < 8; i++) drive(ST, 32'h4000 + 32'(i * 4), 32'(i), 1'b0, 0);
    chk(spec_active == 1'b1, "R10 eight stores fit", spec_active, 1);
    expect_mem(1'b1, LK, 32'h1, "R9 real acquire");
    drive(ST, 32'h4020, 32'h9, 1'b0, 0);
    check_abort("R10 store buffer overflow", 3);
    release_real();

    // R10 read set capacity (lock line plus seven loads fill it)
    acquire();
    for (int i = 0; i < 7; i++) begin
      expect_mem(1'b0, 32'h8000 + 32'(i * 64), 32'h0, "R10 load to memory");
      drive(LD, 32'h8000 + 32'(i * 64), 32'h0, 1'b0, 0);
    end
    chk(spec_active == 1'b1, "R10 read set full", spec_active, 1);
    expect_mem(1'b1, LK, 32'h1, "R9 real acquire");
    drive(LD, 32'h8000 + 32'(7 * 64), 32'h0, 1'b0, 0);
    check_abort("R10 read set overflow", 4);
    release_real();

    // R10 uncached access
    acquire();
    expect_mem(1'b1, LK, 32'h1, "R9 real acquire");
    drive(UCL, 32'h9000, 32'h0, 1'b0, 0);
    check_abort("R10 uncached", 5);
    release_real();

    // R10 lock store with a different value
    acquire();
    expect_mem(1'b1, LK, 32'h1, "R9 real acquire");
    drive(ST, LK, 32'h5, 1'b0, 0);
    check_abort("R10 bad release", 6);
    release_real();

    // R6 empty section
    acquire();
    drive(ST, LK, 32'h0, 1'b0, 0);
    n = 0;
    while (!(sec_commit || sec_abort) && n < 50) begin @(negedge clk); n++; end
    chk(sec_commit && n == 1, "R6 empty commit", n, 1);
    chk(abort_count == 16'd6, "R12 count unchanged on commit", abort_count, 6);

    repeat (3) @(negedge clk);
    chk(exp_q.size() == 0, "R2 all memory items seen", exp_q.size(), 0);
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule